// File: doc/BRIEF.md
# Event Flag and Wait-for-Event Wake Controller

This block holds a processor's one-bit event flag and the sleep and wake logic behind a wait-for-event instruction. A number of interrupt lines feed it. Each line has its own pending bit, which a request pulse sets and a clear input resets. The block notes the cycle in which a line moves from idle to pending. When the send-on-pending control bit is high, that move raises the event flag. This happens whatever the line's enable, priority and global mask state. A send-event pulse raises the flag directly.

A wait-for-event request always consumes the flag. If nothing is waiting, the block enters sleep. While asleep it watches for two things: an event source, or a pending line that is enabled, unmasked and of sufficient priority. When either appears, the block leaves sleep on the next edge, gives a one-cycle wake pulse and leaves the flag clear. A separate output reports that an interrupt would be taken, which means some line is pending, enabled, of sufficient priority and not blocked by the global mask.

Top module: `evt_wake_ctrl`

## Requirements
- R1: After reset all pending bits are 0, the event flag is 0, the sleep output is 0 and the wake pulse is 0.
- R2: While awake, a send-event pulse with no wait request in the same cycle makes the event flag 1 after the next edge.
- R3: With the send-on-pending bit at 1, a line whose pending bit goes from 0 to 1 sets the event flag. This holds even when that line is disabled, globally masked or of insufficient priority.
- R4: A request on a line that is already pending does not set the event flag.
- R5: The exception-taken output is 1 exactly when some line is pending with its enable at 1 and its priority-sufficient input at 1, and the global mask is 0.
- R6: The pending bit of line i becomes 1 after an edge with a request on line i, and becomes 0 after an edge with a clear on line i. When both arrive in the same cycle, the request wins.
- R7: With the send-on-pending bit at 0, new pending transitions leave the event flag unchanged.
- R8: A wait request while awake clears the flag. If the flag was 0, no event source fires in that cycle and no interrupt qualifies, the sleep output goes to 1 on the next edge.
- R9: A wait request while awake does not sleep if the flag is 1, if an event source fires in the same cycle, or if an interrupt qualifies. In each case the flag is 0 after the edge.
- R10: While asleep, an event source or a qualifying interrupt drops the sleep output on the next edge and raises the wake output for exactly one cycle. The flag is left at 0.
- R11: A wait request while already asleep has no effect, and the wake output is never 1 except in the cycle right after a sleep exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sev_i | input | 1 | Send-event pulse |
| irq_req_i | input | N_LINES | Per-line interrupt request pulses |
| irq_clr_i | input | N_LINES | Per-line pending clear |
| irq_en_i | input | N_LINES | Per-line enable |
| prio_ok_i | input | N_LINES | Per-line priority-sufficient indication |
| glb_mask_i | input | 1 | Global interrupt mask, 1 blocks exception entry |
| sop_en_i | input | 1 | Send-event-on-pending control |
| wfe_i | input | 1 | Wait-for-event request pulse |
| pend_o | output | N_LINES | Pending bits |
| evt_flag_o | output | 1 | Event flag |
| exc_take_o | output | 1 | Some interrupt would be taken |
| sleep_o | output | 1 | Block is in the sleep state |
| wake_o | output | 1 | One-cycle pulse on leaving sleep |

## Verification
On every cycle the assertions check the state transitions that follow from the current flags and inputs: a send-event sets the flag, a request wins against a clear, the mask suppresses the exception output, sleep entry and refusal follow a wait request, and the wake pulse lasts a single cycle after a sleep exit. Some behaviour cannot be seen from one edge alone. This includes the absence of a second flag set for a line that is already pending, a disabled or masked line waking a sleeping block through the flag, and the one-cycle lag between a request arriving and that line qualifying for wake. The directed scenarios in the bench cover these sequences.

// File: rtl/evw_pkg.sv
package evw_pkg;

  typedef enum logic {
    PWR_AWAKE  = 1'b0,
    PWR_ASLEEP = 1'b1
  } pwr_state_e;

  // Flag value after an awake cycle with no wait request.
  function automatic logic flag_hold_or_set(input logic flag_now, input logic src);
    return flag_now | src;
  endfunction

  // Whether a wait request while awake must be refused.
  function automatic logic wait_refused(input logic flag_now, input logic src,
                                        input logic qual);
    return flag_now | src | qual;
  endfunction

endpackage

// File: rtl/evw_pending.sv
module evw_pending #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] clr_i,
  input  logic [N_LINES-1:0] en_i,
  input  logic [N_LINES-1:0] prio_ok_i,
  input  logic               glb_mask_i,
  output logic [N_LINES-1:0] pend_o,
  output logic               new_pend_any_o,
  output logic               qual_any_o
);

  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] rising_w;
  logic [N_LINES-1:0] eligible_w;

  // Lines moving from idle to pending this cycle.
  function automatic logic [N_LINES-1:0] fresh_lines(input logic [N_LINES-1:0] req,
                                                      input logic [N_LINES-1:0] pend);
    return req & ~pend;
  endfunction

  function automatic logic [N_LINES-1:0] ready_lines(input logic [N_LINES-1:0] pend,
                                                      input logic [N_LINES-1:0] en,
                                                      input logic [N_LINES-1:0] prio);
    return pend & en & prio;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < N_LINES; gi++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q[gi] <= 1'b0;
        else if (req_i[gi])  pend_q[gi] <= 1'b1;
        else if (clr_i[gi])  pend_q[gi] <= 1'b0;
      end
    end
  endgenerate

  assign rising_w       = fresh_lines(req_i, pend_q);
  assign eligible_w     = ready_lines(pend_q, en_i, prio_ok_i);
  assign new_pend_any_o = |rising_w;
  assign qual_any_o     = (|eligible_w) & ~glb_mask_i;
  assign pend_o         = pend_q;

  // R6: a request always lands, even against a clear
  p_req_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> ((pend_q & $past(req_i)) == $past(req_i)));

  // R6: a clear without a request empties the line
  p_clr_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~req_i) != '0) |=> ((pend_q & $past(clr_i & ~req_i)) == '0));

endmodule

// File: rtl/evw_core.sv
module evw_core
  import evw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sev_i,
  input  logic sop_en_i,
  input  logic new_pend_any_i,
  input  logic qual_any_i,
  input  logic wfe_i,
  output logic flag_o,
  output logic sleep_o,
  output logic wake_o
);

  pwr_state_e state_q;
  logic       flag_q;
  logic       wake_q;
  logic       evt_src_w;
  logic       wake_cond_w;
  logic       asleep_w;

  assign evt_src_w   = sev_i | (sop_en_i & new_pend_any_i);
  assign wake_cond_w = evt_src_w | qual_any_i;
  assign asleep_w    = (state_q == PWR_ASLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_AWAKE;
      flag_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= asleep_w & wake_cond_w;
      if (asleep_w) begin
        flag_q <= 1'b0;
        if (wake_cond_w) state_q <= PWR_AWAKE;
      end else if (wfe_i) begin
        flag_q <= 1'b0;
        if (!wait_refused(flag_q, evt_src_w, qual_any_i)) state_q <= PWR_ASLEEP;
      end else begin
        flag_q <= flag_hold_or_set(flag_q, evt_src_w);
      end
    end
  end

  assign flag_o  = flag_q;
  assign sleep_o = asleep_w;
  assign wake_o  = wake_q;

  p_sev_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && !wfe_i && sev_i) |=> flag_o);

  p_flag_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && !flag_o && !sev_i && !sop_en_i) |=> !flag_o);

  p_sleep_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && wfe_i && !flag_o && !sev_i && !(sop_en_i && new_pend_any_i) && !qual_any_i)
      |=> (sleep_o && !flag_o));

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && wfe_i && (flag_o || sev_i || qual_any_i)) |=> (!sleep_o && !flag_o));

  p_wake_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && (sev_i || qual_any_i)) |=> (wake_o && !sleep_o && !flag_o));

  p_wake_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  p_wake_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o) |=> !wake_o || $past(sleep_o));

endmodule

// File: rtl/evt_wake_ctrl.sv
module evt_wake_ctrl #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sev_i,
  input  logic [N_LINES-1:0] irq_req_i,
  input  logic [N_LINES-1:0] irq_clr_i,
  input  logic [N_LINES-1:0] irq_en_i,
  input  logic [N_LINES-1:0] prio_ok_i,
  input  logic               glb_mask_i,
  input  logic               sop_en_i,
  input  logic               wfe_i,
  output logic [N_LINES-1:0] pend_o,
  output logic               evt_flag_o,
  output logic               exc_take_o,
  output logic               sleep_o,
  output logic               wake_o
);

  logic new_pend_any_w;
  logic qual_any_w;

  evw_pending #(.N_LINES(N_LINES)) u_pending (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_i          (irq_req_i),
    .clr_i          (irq_clr_i),
    .en_i           (irq_en_i),
    .prio_ok_i      (prio_ok_i),
    .glb_mask_i     (glb_mask_i),
    .pend_o         (pend_o),
    .new_pend_any_o (new_pend_any_w),
    .qual_any_o     (qual_any_w)
  );

  evw_core u_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .sev_i          (sev_i),
    .sop_en_i       (sop_en_i),
    .new_pend_any_i (new_pend_any_w),
    .qual_any_i     (qual_any_w),
    .wfe_i          (wfe_i),
    .flag_o         (evt_flag_o),
    .sleep_o        (sleep_o),
    .wake_o         (wake_o)
  );

  assign exc_take_o = qual_any_w;

  // R5: the global mask keeps any interrupt from being taken
  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    glb_mask_i |-> !exc_take_o);

  // R5: a taken interrupt needs a pending line
  p_take_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_o |-> (pend_o != '0));

endmodule

// File: tb/test_evt_wake_ctrl.sv
`timescale 1ns/1ps
module test_evt_wake_ctrl;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sev = 1'b0, glb_mask = 1'b0, sop_en = 1'b0, wfe = 1'b0;
  logic [N-1:0] req = '0, clr = '0, en = '0, prio = '0;
  logic [N-1:0] pend;
  logic flag, exc, sleep, wake;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  evt_wake_ctrl #(.N_LINES(N)) i_evt_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sev_i(sev), .irq_req_i(req), .irq_clr_i(clr),
    .irq_en_i(en), .prio_ok_i(prio), .glb_mask_i(glb_mask), .sop_en_i(sop_en),
    .wfe_i(wfe), .pend_o(pend), .evt_flag_o(flag), .exc_take_o(exc),
    .sleep_o(sleep), .wake_o(wake)
  );

  task automatic chk(input string req_tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  // one edge, then release pulses and settle
  task automatic step();
    @(posedge clk); #2;
    sev = 1'b0; wfe = 1'b0; req = '0; clr = '0;
    #1;
  endtask

  task automatic clear_all();
    clr = '1; step(); en = '0; prio = '0; glb_mask = 1'b0; sop_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1", "pend", pend, '0);
    chk("R1", "flag", N'(flag), '0);
    chk("R1", "sleep", N'(sleep), '0);
    chk("R1", "wake", N'(wake), '0);
    chk("R1", "exc", N'(exc), '0);
  endtask

  task automatic t_sev_then_wait();
    sev = 1'b1; step();
    chk("R2", "flag after sev", N'(flag), 1);
    wfe = 1'b1; step();
    chk("R9", "no sleep with flag set", N'(sleep), 0);
    chk("R9", "flag consumed", N'(flag), 0);
  endtask

  task automatic t_sleep_and_sev_wake();
    wfe = 1'b1; step();
    chk("R8", "sleep entered", N'(sleep), 1);
    chk("R11", "no wake on entry", N'(wake), 0);
    wfe = 1'b1; step();
    chk("R11", "wait while asleep ignored", N'(sleep), 1);
    chk("R11", "no wake while asleep", N'(wake), 0);
    sev = 1'b1; step();
    chk("R10", "sleep left", N'(sleep), 0);
    chk("R10", "wake pulse", N'(wake), 1);
    chk("R10", "flag clear", N'(flag), 0);
    step();
    chk("R10", "wake one cycle", N'(wake), 0);
  endtask

  task automatic t_send_on_pending();
    sop_en = 1'b1;
    req[3] = 1'b1; step();
    chk("R6", "line 3 pending", pend, N'(1) << 3);
    chk("R3", "flag from disabled line", N'(flag), 1);
    chk("R5", "disabled line not taken", N'(exc), 0);
    wfe = 1'b1; step();
    chk("R9", "flag consumed", N'(flag), 0);
    req[3] = 1'b1; step();
    chk("R4", "repeat request no flag", N'(flag), 0);
    req[3] = 1'b1; clr[3] = 1'b1; step();
    chk("R6", "request beats clear", pend, N'(1) << 3);
    clr[3] = 1'b1; step();
    chk("R6", "clear empties", pend, '0);
    clear_all();
  endtask

  task automatic t_pending_no_sop();
    req[5] = 1'b1; step();
    chk("R7", "pending set", pend, N'(1) << 5);
    chk("R7", "flag untouched", N'(flag), 0);
    clear_all();
  endtask

  task automatic t_masked_wakes();
    sop_en = 1'b1; glb_mask = 1'b1;
    en[7] = 1'b1; prio[7] = 1'b1;
    wfe = 1'b1; step();
    chk("R8", "asleep", N'(sleep), 1);
    req[7] = 1'b1; step();
    chk("R5", "mask blocks exception", N'(exc), 0);
    chk("R3", "masked line wakes", N'(sleep), 0);
    chk("R10", "wake pulse", N'(wake), 1);
    chk("R10", "flag consumed", N'(flag), 0);
    step();
    clear_all();
  endtask

  task automatic t_qualifying_wake();
    en[2] = 1'b1; prio[2] = 1'b1;
    wfe = 1'b1; step();
    chk("R8", "asleep", N'(sleep), 1);
    req[2] = 1'b1; step();
    chk("R5", "taken when enabled", N'(exc), 1);
    chk("R10", "still asleep one edge", N'(sleep), 1);
    step();
    chk("R10", "woken by interrupt", N'(sleep), 0);
    chk("R10", "wake pulse", N'(wake), 1);
    chk("R7", "flag stays clear", N'(flag), 0);
    wfe = 1'b1; step();
    chk("R9", "no sleep with qualifying irq", N'(sleep), 0);
    prio[2] = 1'b0; #1;
    chk("R5", "low priority not taken", N'(exc), 0);
    clear_all();
  endtask

  task automatic t_race();
    wfe = 1'b1; sev = 1'b1; step();
    chk("R9", "same-cycle sev no sleep", N'(sleep), 0);
    chk("R9", "flag consumed", N'(flag), 0);
  endtask

  initial begin
    fork
      begin
        #40; rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_sev_then_wait();
        t_sleep_and_sev_wake();
        t_send_on_pending();
        t_pending_no_sop();
        t_masked_wakes();
        t_qualifying_wake();
        t_race();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired: actual hung expected done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule